// File: doc/BRIEF.md
# Accumulator ALU with Decimal Adjust and Iterative Multiply/Divide

This block is the arithmetic and logic unit of an 8-bit accumulator-based core. The core presents an operation code, the accumulator, a second operand, the B register, a 16-bit pointer and the current carry, auxiliary-carry and overflow flags. The block returns a result byte, a high result byte, an updated pointer and the three updated flags. Operand fetch, writeback and instruction sequencing stay in the core. The core writes back only the outputs that belong to the operation it issued.

Most operations are combinational. The result is valid in the same cycle as the operation code and operands. Multiply and divide run one bit per clock in a shared shift unit. The core pulses `start_i` with the multiply or divide code applied. The block raises `busy_o` and later pulses `done_o`. The results stay held on the outputs until the next accepted start, for as long as the core keeps that code applied. Flags that an operation does not define pass through from the flag inputs unchanged.

Operation codes on `op_i`: 0 add, 1 add with carry, 2 subtract with borrow, 3 increment, 4 decrement, 5 pointer increment, 6 pointer decrement, 7 multiply, 8 divide, 9 decimal adjust, 10 AND, 11 OR. Codes 12 to 15 are unused.

Top module: `acc_alu`

## Requirements
- R1: Add (op 0) gives `res_o` = (acc + opnd) mod 256, and add with carry (op 1) gives (acc + opnd + cy_i) mod 256. Op 0 ignores `cy_i`. For both, `cy_o` is the carry out of bit 7 and `ac_o` is the carry out of bit 3. `ov_o` is set when the signed sum lies outside -128..127.
- R2: Subtract with borrow (op 2) gives `res_o` = (acc - opnd - cy_i) mod 256. `cy_o` is set on a borrow into bit 7 and `ac_o` on a borrow into bit 3. `ov_o` is set when the signed difference lies outside -128..127.
- R3: Increment (op 3) and decrement (op 4) give (opnd ± 1) mod 256 on `res_o`. All three flags equal their inputs.
- R4: Pointer increment (op 5) and pointer decrement (op 6) give (ptr ± 1) mod 65536 on `ptr_o`. All three flags equal their inputs.
- R5: AND (op 10) and OR (op 11) give acc & opnd and acc | opnd on `res_o`. All three flags equal their inputs.
- R6: Decimal adjust (op 9) works in two steps. First, 0x06 is added to acc when its low nibble exceeds 9 or `ac_i` is set. Second, 0x60 is added to that intermediate value when its high nibble exceeds 9, or `cy_i` is set, or the first step carried out of bit 7. When the second step applies, `cy_o` is 1; otherwise `cy_o` equals `cy_i`. `ac_o` and `ov_o` pass through.
- R7: Multiply (op 7) started with `start_i` pulses `done_o` for exactly one cycle, 8 clock edges after the edge that accepted the start. `busy_o` is high in between. At that point `res_o` holds the low byte of acc × breg and `res_hi_o` holds the high byte. `cy_o` is 0, `ov_o` is 1 exactly when the product exceeds 255, and `ac_o` passes through.
- R8: Divide (op 8) with a nonzero divisor completes with the same timing as R7. `res_o` holds acc / breg, `res_hi_o` holds acc mod breg, and `cy_o` and `ov_o` are 0.
- R9: Divide with breg = 0 completes with `ov_o` = 1 and `cy_o` = 0. The result bytes are unspecified.
- R10: A start while `busy_o` is high has no effect on the running operation. A start applied with an operation code other than 7 or 8 does not raise `busy_o`.
- R11: After a synchronous active-low reset, `busy_o` and `done_o` are 0.
- R12: For every combinational operation `res_hi_o` is 0. Ops other than 5 and 6 give `ptr_o` = `ptr_i`. Unused codes 12 to 15 give `res_o` = acc with all three flags passed through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Operation code |
| start_i | input | 1 | Start pulse for multiply or divide |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| breg_i | input | 8 | B register, the multiplier or divisor |
| ptr_i | input | 16 | Pointer operand |
| cy_i | input | 1 | Carry flag in |
| ac_i | input | 1 | Auxiliary carry flag in |
| ov_i | input | 1 | Overflow flag in |
| res_o | output | 8 | Result byte (the product low byte or the quotient for multiply and divide) |
| res_hi_o | output | 8 | High result byte (the product high byte or the remainder) |
| ptr_o | output | 16 | Updated pointer |
| cy_o | output | 1 | Carry flag out |
| ac_o | output | 1 | Auxiliary carry flag out |
| ov_o | output | 1 | Overflow flag out |
| busy_o | output | 1 | Multiply or divide in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The combinational paths hold no state, so a flag or carry-chain fault shows on the outputs in the same cycle as the operands. The random and directed cases compare every output at that point. The only internal state is the shift unit: its step counter, the partial remainder or partial product, and the latched divisor. A wrong value in any of these appears at the ports by the `done_o` pulse at the latest, because the pulse time and both result bytes are compared on every completion. A corrupted busy flag shows at once, either as a lost `busy_o` or as a second start that changes the running result.

// File: rtl/acc_alu_pkg.sv
// Package: operation codes shared by the ALU and its users.
// Assumes the core drives op_i with one of these encodings.
package acc_alu_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUBB = 4'd2,
        OP_INC  = 4'd3,
        OP_DEC  = 4'd4,
        OP_PINC = 4'd5,
        OP_PDEC = 4'd6,
        OP_MUL  = 4'd7,
        OP_DIV  = 4'd8,
        OP_DA   = 4'd9,
        OP_AND  = 4'd10,
        OP_OR   = 4'd11,
        OP_RS12 = 4'd12,
        OP_RS13 = 4'd13,
        OP_RS14 = 4'd14,
        OP_RS15 = 4'd15
    } alu_op_e;
endpackage

// File: rtl/acc_alu_addsub.sv
// Combinational adder/subtractor with carry, half-carry and signed-overflow flags.
// Assumes DW is even. The half carry is taken at the DW/2 boundary.
// When sub_i is set, cin_i is a borrow and cy_o reports a borrow.
module acc_alu_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    input  logic          sub_i,
    output logic [DW-1:0] sum_o,
    output logic          cy_o,
    output logic          ac_o,
    output logic          ov_o
);
    localparam int HW = DW / 2;

    logic [DW:0] full;
    logic [HW:0] half;

    // Full-width and half-width sums; the top bit is the carry or borrow out.
    always_comb begin
        if (sub_i) begin
            full = {1'b0, a_i} - {1'b0, b_i} - (DW+1)'(cin_i);
            half = {1'b0, a_i[HW-1:0]} - {1'b0, b_i[HW-1:0]} - (HW+1)'(cin_i);
            ov_o = (a_i[DW-1] != b_i[DW-1]) && (full[DW-1] != a_i[DW-1]);
        end else begin
            full = {1'b0, a_i} + {1'b0, b_i} + (DW+1)'(cin_i);
            half = {1'b0, a_i[HW-1:0]} + {1'b0, b_i[HW-1:0]} + (HW+1)'(cin_i);
            ov_o = (a_i[DW-1] == b_i[DW-1]) && (full[DW-1] != a_i[DW-1]);
        end
    end

    assign sum_o = full[DW-1:0];
    assign cy_o  = full[DW];
    assign ac_o  = half[HW];
endmodule

// File: rtl/acc_alu_bcd.sv
// Decimal adjust of a byte that holds the sum of two packed BCD values.
// Assumes an 8-bit byte of two nibbles. The carry can be set but never cleared.
module acc_alu_bcd (
    input  logic [7:0] a_i,
    input  logic       cy_i,
    input  logic       ac_i,
    output logic [7:0] res_o,
    output logic       cy_o
);
    logic [8:0] step1;
    logic [8:0] step2;
    logic       hi_fix;

    // Low-nibble correction, then high-nibble correction on the intermediate value.
    always_comb begin
        step1  = (a_i[3:0] > 4'd9 || ac_i) ? ({1'b0, a_i} + 9'h006) : {1'b0, a_i};
        hi_fix = (step1[7:4] > 4'd9) || cy_i || step1[8];
        step2  = hi_fix ? ({1'b0, step1[7:0]} + 9'h060) : {1'b0, step1[7:0]};
        res_o  = step2[7:0];
        cy_o   = cy_i | hi_fix;
    end
endmodule

// File: rtl/acc_alu_seq.sv
// Shared shift unit that multiplies or divides one bit per clock.
// Multiply is shift-and-add and divide is restoring division; each takes DW steps.
// A start is accepted only while idle. Results hold until the next accepted start.
// Assumes the caller keeps start_i low unless a multiply or divide is meant.
module acc_alu_seq #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          div_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] lo_o,
    output logic [DW-1:0] hi_o,
    output logic          ov_o
);
    localparam int CW = (DW > 2) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    logic          busy_q, done_q, div_q, ov_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] hi_q, lo_q, b_q;
    logic [DW-1:0] hi_n, lo_n;
    logic [DW:0]   msum, rem_s, rem_d;
    logic          ge;

    // One step: add the multiplicand under the current multiplier bit, or do a trial subtraction.
    always_comb begin
        msum  = {1'b0, hi_q} + (lo_q[0] ? {1'b0, b_q} : '0);
        rem_s = {hi_q, lo_q[DW-1]};
        ge    = rem_s >= {1'b0, b_q};
        rem_d = ge ? (rem_s - {1'b0, b_q}) : rem_s;
        if (div_q) begin
            hi_n = rem_d[DW-1:0];
            lo_n = {lo_q[DW-2:0], ge};
        end else begin
            hi_n = msum[DW:1];
            lo_n = {msum[0], lo_q[DW-1:1]};
        end
    end

    // Sequencer: load on start, step while busy, pulse done after the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            div_q  <= 1'b0;
            ov_q   <= 1'b0;
            cnt_q  <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
            b_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q && start_i) begin
                busy_q <= 1'b1;
                div_q  <= div_i;
                cnt_q  <= '0;
                hi_q   <= '0;
                lo_q   <= a_i;
                b_q    <= b_i;
                ov_q   <= 1'b0;
            end else if (busy_q) begin
                hi_q  <= hi_n;
                lo_q  <= lo_n;
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    ov_q   <= div_q ? (b_q == '0) : (hi_n != '0);
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign lo_o   = lo_q;
    assign hi_o   = hi_q;
    assign ov_o   = ov_q;

    // R7: done is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R10: an accepted start makes the unit busy on the next cycle
    p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_q) |=> busy_q);
    // R7: a multiply completes with overflow exactly when the high byte is nonzero
    p_mul_ov_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !div_q) |-> (ov_q == (hi_q != '0)));
    // R8: a divide by a nonzero value leaves a remainder below the divisor
    p_rem_small_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && div_q && b_q != '0) |-> (hi_q < b_q));
endmodule

// File: rtl/acc_alu.sv
// Accumulator ALU top level. It selects among the adder, the decimal-adjust
// logic, the bitwise and pointer paths, and the held multiply/divide results.
// Assumes the core holds op_i steady while a multiply or divide runs and
// until it has taken the results after done_o.
module acc_alu #(
    parameter int DW = 8,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_i,
    input  logic          start_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] opnd_i,
    input  logic [DW-1:0] breg_i,
    input  logic [PW-1:0] ptr_i,
    input  logic          cy_i,
    input  logic          ac_i,
    input  logic          ov_i,
    output logic [DW-1:0] res_o,
    output logic [DW-1:0] res_hi_o,
    output logic [PW-1:0] ptr_o,
    output logic          cy_o,
    output logic          ac_o,
    output logic          ov_o,
    output logic          busy_o,
    output logic          done_o
);
    import acc_alu_pkg::*;

    alu_op_e       op;
    logic [DW-1:0] as_sum, da_res, md_lo, md_hi;
    logic          as_cy, as_ac, as_ov, da_cy, md_ov, as_cin, md_start;

    assign op       = alu_op_e'(op_i);
    assign as_cin   = (op == OP_ADD) ? 1'b0 : cy_i;
    assign md_start = start_i && (op == OP_MUL || op == OP_DIV);

    acc_alu_addsub #(.DW(DW)) u_addsub (
        .a_i(acc_i), .b_i(opnd_i), .cin_i(as_cin), .sub_i(op == OP_SUBB),
        .sum_o(as_sum), .cy_o(as_cy), .ac_o(as_ac), .ov_o(as_ov)
    );

    acc_alu_bcd u_bcd (
        .a_i(acc_i), .cy_i(cy_i), .ac_i(ac_i), .res_o(da_res), .cy_o(da_cy)
    );

    acc_alu_seq #(.DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(md_start), .div_i(op == OP_DIV),
        .a_i(acc_i), .b_i(breg_i), .busy_o(busy_o), .done_o(done_o),
        .lo_o(md_lo), .hi_o(md_hi), .ov_o(md_ov)
    );

    // Output select: flags pass through unless the operation defines them.
    always_comb begin
        res_o    = acc_i;
        res_hi_o = '0;
        ptr_o    = ptr_i;
        cy_o     = cy_i;
        ac_o     = ac_i;
        ov_o     = ov_i;
        case (op)
            OP_ADD, OP_ADDC, OP_SUBB: begin
                res_o = as_sum;
                cy_o  = as_cy;
                ac_o  = as_ac;
                ov_o  = as_ov;
            end
            OP_INC:  res_o = opnd_i + 1'b1;
            OP_DEC:  res_o = opnd_i - 1'b1;
            OP_PINC: ptr_o = ptr_i + 1'b1;
            OP_PDEC: ptr_o = ptr_i - 1'b1;
            OP_MUL, OP_DIV: begin
                res_o    = md_lo;
                res_hi_o = md_hi;
                cy_o     = 1'b0;
                ov_o     = md_ov;
            end
            OP_DA: begin
                res_o = da_res;
                cy_o  = da_cy;
            end
            OP_AND:  res_o = acc_i & opnd_i;
            OP_OR:   res_o = acc_i | opnd_i;
            default: res_o = acc_i;
        endcase
    end

    // R3: byte increment and decrement leave every flag as it came in
    p_incdec_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INC || op == OP_DEC) |-> (cy_o == cy_i && ac_o == ac_i && ov_o == ov_i));
    // R6: decimal adjust never clears a set carry
    p_da_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DA && cy_i) |-> cy_o);
    // R7: multiply and divide always report a clear carry
    p_md_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_MUL || op == OP_DIV) |-> !cy_o);
    // R12: the high result byte is zero outside multiply and divide
    p_hi_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(op == OP_MUL || op == OP_DIV) |-> (res_hi_o == '0));
endmodule

// File: tb/acc_alu_bench.sv
// Bench: random and directed stimulus, compared against models written from the requirements.
module acc_alu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic        start_i = 1'b0;
    logic [7:0]  acc_i = 8'd0, opnd_i = 8'd0, breg_i = 8'd0;
    logic [15:0] ptr_i = 16'd0;
    logic        cy_i = 1'b0, ac_i = 1'b0, ov_i = 1'b0;
    logic [7:0]  res_o, res_hi_o;
    logic [15:0] ptr_o;
    logic        cy_o, ac_o, ov_o, busy_o, done_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0]  e_res, e_hi;
    logic [15:0] e_ptr;
    logic        e_cy, e_ac, e_ov;

    always #4 clk = ~clk;

    acc_alu u_acc_alu (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .start_i(start_i), .acc_i(acc_i),
        .opnd_i(opnd_i), .breg_i(breg_i), .ptr_i(ptr_i), .cy_i(cy_i), .ac_i(ac_i),
        .ov_i(ov_i), .res_o(res_o), .res_hi_o(res_hi_o), .ptr_o(ptr_o), .cy_o(cy_o),
        .ac_o(ac_o), .ov_o(ov_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1: return "R1";
            4'd2:       return "R2";
            4'd3, 4'd4: return "R3";
            4'd5, 4'd6: return "R4";
            4'd9:       return "R6";
            4'd10, 4'd11: return "R5";
            default:    return "R12";
        endcase
    endfunction

    // Model of the combinational operations, written from R1-style rules
    task automatic model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [15:0] p, input logic c, input logic h, input logic v);
        int t, s;
        logic lc;
        e_res = a; e_hi = 8'd0; e_ptr = p; e_cy = c; e_ac = h; e_ov = v;
        case (op)
            4'd0, 4'd1: begin
                t = int'(a) + int'(b) + ((op == 4'd1) ? int'(c) : 0);
                s = int'($signed(a)) + int'($signed(b)) + ((op == 4'd1) ? int'(c) : 0);
                e_res = t[7:0]; e_cy = (t > 255);
                e_ac = ((int'(a % 16) + int'(b % 16) + ((op == 4'd1) ? int'(c) : 0)) > 15);
                e_ov = (s > 127) || (s < -128);
            end
            4'd2: begin
                t = int'(a) - int'(b) - int'(c);
                s = int'($signed(a)) - int'($signed(b)) - int'(c);
                e_res = t[7:0]; e_cy = (t < 0);
                e_ac = (int'(a % 16) < int'(b % 16) + int'(c));
                e_ov = (s > 127) || (s < -128);
            end
            4'd3: e_res = 8'((int'(b) + 1) % 256);
            4'd4: e_res = 8'((int'(b) + 255) % 256);
            4'd5: e_ptr = 16'((int'(p) + 1) % 65536);
            4'd6: e_ptr = 16'((int'(p) + 65535) % 65536);
            4'd9: begin
                t = int'(a);
                if ((a % 16) > 9 || h) t = t + 6;
                lc = (t > 255);
                t = t % 256;
                if ((t / 16) > 9 || c || lc) begin t = t + 96; e_cy = 1'b1; end
                e_res = 8'(t % 256);
            end
            4'd10: e_res = a & b;
            4'd11: e_res = a | b;
            default: e_res = a;
        endcase
    endtask

    // Apply one combinational operation and compare every output
    task automatic comb_case(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                             input logic [15:0] p, input logic c, input logic h, input logic v);
        string tg;
        @(negedge clk);
        op_i = op; acc_i = a; opnd_i = b; ptr_i = p; cy_i = c; ac_i = h; ov_i = v;
        #1;
        model(op, a, b, p, c, h, v);
        tg = tag_of(op);
        chk({tg, " res"}, 32'(res_o), 32'(e_res));
        chk({tg, " cy"}, 32'(cy_o), 32'(e_cy));
        chk({tg, " ac"}, 32'(ac_o), 32'(e_ac));
        chk({tg, " ov"}, 32'(ov_o), 32'(e_ov));
        chk("R12 res_hi", 32'(res_hi_o), 32'(e_hi));
        chk({tg, " ptr"}, 32'(ptr_o), 32'(e_ptr));
    endtask

    // Run a multiply or divide through the start/done handshake and check it
    task automatic md_case(input logic is_div, input logic [7:0] a, input logic [7:0] b,
                           input logic h, input logic poke);
        int n;
        int p;
        string tg;
        tg = is_div ? ((b == 8'd0) ? "R9" : "R8") : "R7";
        @(negedge clk);
        op_i = is_div ? 4'd8 : 4'd7; acc_i = a; breg_i = b; ac_i = h; cy_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk({tg, " busy after start"}, 32'(busy_o), 32'd1);
        if (poke) begin
            acc_i = ~a; breg_i = b + 8'd1; start_i = 1'b1;
        end
        n = 0;
        while (!done_o && n < 40) begin
            @(negedge clk);
            start_i = 1'b0;
            n++;
        end
        chk({tg, " latency"}, 32'(n), 32'd8);
        p = int'(a) * int'(b);
        chk({tg, " cy"}, 32'(cy_o), 32'd0);
        chk({tg, " ac pass"}, 32'(ac_o), 32'(h));
        if (!is_div) begin
            chk(poke ? "R10 ignored start lo" : "R7 lo", 32'(res_o), 32'(p % 256));
            chk("R7 hi", 32'(res_hi_o), 32'(p / 256));
            chk("R7 ov", 32'(ov_o), 32'(p > 255));
        end else if (b != 8'd0) begin
            chk(poke ? "R10 ignored start quot" : "R8 quot", 32'(res_o), 32'(a / b));
            chk("R8 rem", 32'(res_hi_o), 32'(a % b));
            chk("R8 ov", 32'(ov_o), 32'd0);
        end else begin
            chk("R9 ov", 32'(ov_o), 32'd1);
        end
        @(negedge clk);
        chk({tg, " done pulse"}, 32'(done_o), 32'd0);
        chk({tg, " busy idle"}, 32'(busy_o), 32'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [3:0] rop;
        void'($urandom(32'h1F2E3D4C));
        start_i = 1'b1;
        op_i = 4'd7;
        repeat (3) @(negedge clk);
        #1;
        chk("R11 busy in reset", 32'(busy_o), 32'd0);
        chk("R11 done in reset", 32'(done_o), 32'd0);
        start_i = 1'b0;
        op_i = 4'd0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 busy after reset", 32'(busy_o), 32'd0);
        chk("R11 done after reset", 32'(done_o), 32'd0);

        // Directed corners for R1, R2, R3, R4, R6, R12
        comb_case(4'd0, 8'hFF, 8'h01, 16'h0, 1'b1, 1'b0, 1'b0);
        comb_case(4'd1, 8'h7F, 8'h00, 16'h0, 1'b1, 1'b0, 1'b0);
        comb_case(4'd1, 8'h0F, 8'h00, 16'h0, 1'b1, 1'b0, 1'b0);
        comb_case(4'd2, 8'h80, 8'h01, 16'h0, 1'b0, 1'b0, 1'b0);
        comb_case(4'd2, 8'h00, 8'h00, 16'h0, 1'b1, 1'b0, 1'b0);
        comb_case(4'd3, 8'h00, 8'hFF, 16'h0, 1'b1, 1'b1, 1'b1);
        comb_case(4'd4, 8'h00, 8'h00, 16'h0, 1'b0, 1'b1, 1'b0);
        comb_case(4'd5, 8'h00, 8'h00, 16'hFFFF, 1'b0, 1'b0, 1'b1);
        comb_case(4'd6, 8'h00, 8'h00, 16'h0000, 1'b1, 1'b0, 1'b0);
        comb_case(4'd9, 8'h9A, 8'h00, 16'h0, 1'b0, 1'b0, 1'b0);
        comb_case(4'd9, 8'h99, 8'h00, 16'h0, 1'b0, 1'b0, 1'b0);
        comb_case(4'd9, 8'h12, 8'h00, 16'h0, 1'b1, 1'b1, 1'b0);
        comb_case(4'd9, 8'hFA, 8'h00, 16'h0, 1'b0, 1'b0, 1'b1);
        comb_case(4'd13, 8'h5A, 8'hA5, 16'h1234, 1'b1, 1'b0, 1'b1);

        // Random combinational operations (R1 through R6, R12)
        for (int i = 0; i < 3000; i++) begin
            rop = 4'($urandom_range(0, 15));
            if (rop == 4'd7 || rop == 4'd8) rop = 4'd10 + 4'(i % 2);
            comb_case(rop, 8'($urandom), 8'($urandom), 16'($urandom),
                      1'($urandom), 1'($urandom), 1'($urandom));
        end

        // R10: a start under a non-multiply code does not start the unit
        @(negedge clk);
        op_i = 4'd0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R10 start with add code", 32'(busy_o), 32'd0);

        // Directed multiply and divide corners (R7, R8, R9, R10)
        md_case(1'b0, 8'hFF, 8'hFF, 1'b1, 1'b0);
        md_case(1'b0, 8'h0F, 8'h11, 1'b0, 1'b0);
        md_case(1'b0, 8'h00, 8'h7B, 1'b0, 1'b0);
        md_case(1'b1, 8'hFB, 8'h12, 1'b0, 1'b0);
        md_case(1'b1, 8'h05, 8'h09, 1'b1, 1'b0);
        md_case(1'b1, 8'h40, 8'h00, 1'b0, 1'b0);
        md_case(1'b0, 8'h03, 8'h05, 1'b0, 1'b1);
        md_case(1'b1, 8'hC8, 8'h07, 1'b0, 1'b1);

        // Random multiply and divide
        for (int i = 0; i < 300; i++) begin
            md_case(1'($urandom), 8'($urandom), 8'($urandom_range(0, 255)),
                    1'($urandom), 1'(i % 7 == 0));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule